// File: doc/BRIEF.md
# Multi-Channel Double-Buffered Converter Update Controller

This block sits on a processor write bus and drives a bank of converter channels. Each channel holds two 8-bit registers: a staging register and an output register. The output register drives that channel's converter word. Software updates a channel in two separate steps. First it writes a byte to the channel's own address, which fills the staging register. Then it writes to one transfer address that all channels share. That transfer copies every staging register into its output register on the same clock edge, so all outputs move together.

A channel counts as pending from the moment its staging register is written until the next transfer. The pending flags are visible at the ports. A global freeze input blocks every staging write, so a second bus master that reuses the same addresses cannot disturb the outputs. Freeze does not block transfers.

Channel `i` is at address `BASE + i`, for `i` from 0 to `N_CH - 1`. The transfer address is `BASE + N_CH`. The write data on a transfer access is ignored.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset, every converter word and every pending flag is 0.
- R2: A write with `freeze` low to address `BASE + i` stores the data in channel `i`'s staging register and sets `pending[i]` on the next clock edge. No converter word changes on that edge.
- R3: A write to `BASE + N_CH` copies all staging registers into their output registers on a single clock edge, and clears all pending flags on that same edge.
- R4: At a transfer, a channel that was not written since the previous transfer keeps its converter word.
- R5: While `freeze` is high, writes to channel addresses change no staging register and no pending flag. A later transfer therefore shows the old data.
- R6: A transfer write performs the transfer whether `freeze` is high or low.
- R7: Writes to addresses outside `BASE` to `BASE + N_CH` change no staging register, no output and no pending flag.
- R8: When a channel is written several times before a transfer, the transfer shows the last value written.
- R9: When `bus_wr` is low, the address and data inputs have no effect.
- R10: Channel `i`'s word appears on `dac_word[8*i+7 : 8*i]`. Output registers change only on transfer edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Write address |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| freeze | input | 1 | High blocks all staging-register loads |
| dac_word | output | N_CH*DW | Converter words, channel 0 in the low byte |
| pending | output | N_CH | Per-channel flag: staged data not yet transferred |

## Verification
The bench targets these corner cases:

- A channel left untouched across a transfer must keep its word. A design that clears or reloads unwritten channels would change it.
- A frozen write followed by a transfer must show the old data. A design that gates only the pending flag, and not the load, would expose the new byte.
- A transfer issued during freeze must still clear the pending flags and move the staged data. A design that gates the transfer with freeze would leave stale outputs.
- Addresses just below `BASE` and just above the transfer address must be ignored. An off-by-one decode would load a neighbouring channel.
- A write must not reach the converter word until a transfer. A design whose outputs follow the write directly would fail this.

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl #(
  parameter int N_CH = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_wr,
  input  logic               freeze,
  output logic [N_CH*DW-1:0] dac_word,
  output logic [N_CH-1:0]    pending
);
  localparam logic [AW-1:0] XFER_ADDR = BASE + AW'(N_CH);

  logic xfer;
  assign xfer = bus_wr && (bus_addr == XFER_ADDR);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [DW-1:0] stage_q, out_q;
    logic          pend_q;
    logic          load;

    assign load = bus_wr && !freeze && (bus_addr == BASE + AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        out_q   <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (load) begin
          stage_q <= bus_wdata;
          pend_q  <= 1'b1;
        end else if (xfer) begin
          pend_q  <= 1'b0;
        end
        if (xfer) out_q <= stage_q;
      end
    end

    assign dac_word[g*DW +: DW] = out_q;
    assign pending[g]           = pend_q;
  end
endmodule

// File: rtl/dac_bank_ctrl_chk.sv
module dac_bank_ctrl_chk #(
  parameter int N_CH = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               freeze,
  input logic [N_CH*DW-1:0] dac_word,
  input logic [N_CH-1:0]    pending
);
  localparam logic [AW-1:0] XFER_ADDR = BASE + AW'(N_CH);

  logic is_xfer, is_chan;
  assign is_xfer = bus_wr && (bus_addr == XFER_ADDR);
  assign is_chan = bus_wr && (bus_addr >= BASE) && (bus_addr < XFER_ADDR);

  // R2
  load_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chan && !freeze) |=> (pending != '0) && $stable(dac_word));

  // R3
  xfer_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_xfer |=> (pending == '0));

  // R5
  freeze_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chan && freeze) |=> $stable(pending) && $stable(dac_word));

  // R6
  freeze_keeps_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xfer && freeze) |=> (pending == '0));

  // R7
  undecoded_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_chan && !is_xfer) |=> $stable(pending) && $stable(dac_word));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pending) && $stable(dac_word));

  // R10
  out_only_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_xfer |=> $stable(dac_word));
endmodule

bind dac_bank_ctrl dac_bank_ctrl_chk #(.N_CH(N_CH), .DW(DW), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .freeze(freeze), .dac_word(dac_word), .pending(pending)
);

// File: tb/test_dac_bank_ctrl.sv
`timescale 1ns/1ps
module test_dac_bank_ctrl;
  localparam int N_CH = 4;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] BASE = 8'h40;
  localparam logic [AW-1:0] XFER = BASE + AW'(N_CH);

  logic clk = 0, rst_n = 0, bus_wr = 0, freeze = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [N_CH*DW-1:0] dac_word;
  logic [N_CH-1:0] pending;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] stage_m [N_CH];
  logic [DW-1:0] out_m [N_CH];
  logic [N_CH-1:0] pend_m;

  always #2.5 clk = ~clk;

  dac_bank_ctrl #(.N_CH(N_CH), .DW(DW), .AW(AW), .BASE(BASE)) i_dac_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .freeze(freeze), .dac_word(dac_word), .pending(pending)
  );

  function automatic logic [N_CH*DW-1:0] exp_word();
    logic [N_CH*DW-1:0] w;
    for (int i = 0; i < N_CH; i++) w[i*DW +: DW] = out_m[i];
    return w;
  endfunction

  function automatic void model_step(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic frz);
    if (!wr) return;
    if (a == XFER) begin
      for (int i = 0; i < N_CH; i++) out_m[i] = stage_m[i];
      pend_m = '0;
    end else if (a >= BASE && a < XFER && !frz) begin
      stage_m[a - BASE] = d;
      pend_m[a - BASE] = 1'b1;
    end
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (dac_word !== exp_word() || pending !== pend_m) begin
      n_fail++;
      $display("FAIL %s: dac_word=%h pending=%b expected dac_word=%h pending=%b",
               tag, dac_word, pending, exp_word(), pend_m);
    end
  endtask

  task automatic access(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic frz, string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; freeze = frz;
    @(negedge clk);
    bus_wr = 0;
    model_step(wr, a, d, frz);
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N_CH; i++) begin stage_m[i] = '0; out_m[i] = '0; end
    pend_m = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset release");

    access(1, BASE + 0, 8'hA5, 0, "R2 staging write, output unchanged");
    access(1, XFER, 8'h00, 0, "R3 transfer moves word, clears pending");
    access(1, BASE + 1, 8'h3C, 0, "R2 second channel write");
    access(1, BASE + 3, 8'hFF, 0, "R10 top channel write");
    access(1, XFER, 8'h77, 0, "R4 untouched channel keeps word");
    access(1, BASE + 2, 8'h11, 1, "R5 frozen write ignored");
    access(1, XFER, 8'h00, 0, "R5 transfer after frozen write keeps old");
    access(1, BASE + 2, 8'h5A, 0, "R6 stage before frozen transfer");
    access(1, XFER, 8'h00, 1, "R6 transfer while frozen");
    access(1, BASE - 1, 8'hEE, 0, "R7 address below base");
    access(1, XFER + 1, 8'hEE, 0, "R7 address above transfer");
    access(1, 8'h00, 8'hEE, 0, "R7 address zero");
    access(1, XFER, 8'h00, 0, "R7 transfer after undecoded writes");
    access(1, BASE + 1, 8'h01, 0, "R8 first of repeated writes");
    access(1, BASE + 1, 8'h02, 0, "R8 second of repeated writes");
    access(1, XFER, 8'h00, 0, "R8 last write wins");
    access(0, BASE + 0, 8'h99, 0, "R9 strobe low channel address");
    access(0, XFER, 8'h99, 0, "R9 strobe low transfer address");
    access(1, BASE + 0, 8'h80, 0, "R3 stage ch0");
    access(1, BASE + 3, 8'h08, 0, "R3 stage ch3");
    access(1, XFER, 8'h00, 0, "R3 simultaneous update of two channels");

    for (int k = 0; k < 2000; k++) begin
      logic wr;
      logic [AW-1:0] a;
      wr = ($urandom % 10) < 8;
      a = (BASE - AW'(2)) + AW'($urandom % (N_CH + 5));
      access(wr, a, DW'($urandom), ($urandom % 5) == 0, "R10 random traffic");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule